// File: doc/BRIEF.md
# Timer count-enable clock selector

This block turns one of several timing sources into a single-cycle count-enable pulse for a timer counter that runs on the system clock. A 3-bit source field picks the source. It can be the system clock itself, a tap of a shared free-running prescaler (divide by 4, 16, 64, and optionally 256 or 1024), one of four external clock pins, or, where the channel has it, the overflow/underflow strobe of a neighbouring channel. A 2-bit edge field chooses whether rising edges, falling edges or both edges of the chosen source produce a pulse.

External pins are resynchronised with a two-flop chain and edge-detected in the system clock domain. The block remembers the previous level of the selected source. That history is treated as invalid in any cycle where the source field differs from its value in the previous cycle, so a change of source never produces a false pulse. For the undivided clock and the cascade strobe, the edge field is ignored and the block behaves as if rising edges were selected. Per-channel parameters choose which optional sources are present. A code with no source behind it gives no pulses.

Top module: `tmr_cnt_en_sel`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `cnt_en_o` is low.
- R2: With source code 000 and no source change, `cnt_en_o` is high in every cycle, whatever the edge field holds.
- R3: With a prescaler source (code 001 = /4, 010 = /16, 011 = /64) and edge field 00, exactly one pulse appears per N cycles. It appears in the cycle in which the prescaler count, taken modulo N, equals N/2. The prescaler count is 0 during reset and increments on every clock.
- R4: With a prescaler source and edge field 01, the pulse appears in the cycle in which the prescaler count modulo N equals 0 (never in the first cycle after reset).
- R5: With a prescaler source and edge field 10 or 11, pulses appear at both of those points, one every N/2 cycles.
- R6: Codes 100 to 111 select pins A to D when external pins C and D are enabled. Take a pin change set up before clock edge k. It produces a one-cycle pulse in the cycle after edge k+1, provided the edge field selects that direction (00 rising, 01 falling, 1x both). Otherwise it produces none.
- R7: In any cycle where the source field differs from its value in the previous cycle, `cnt_en_o` is low. Even if the newly chosen source is already high, no pulse follows the change.
- R8: When external pins C and D are disabled, code 110 selects /256 if that tap is enabled and no source otherwise. Code 111 selects the cascade strobe if enabled, else /1024 if enabled, else no source.
- R9: With the cascade source selected and the source stable, `cnt_en_o` equals `casc_stb_i` in the same cycle, whatever the edge field holds.
- R10: A code with no source behind it keeps `cnt_en_o` low, whatever the pins and the cascade strobe do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_sel_i | input | 3 | Source select code |
| edge_sel_i | input | 2 | Edge select: 00 rising, 01 falling, 1x both |
| ext_clk_i | input | 4 | External clock pins A (bit 0) to D (bit 3) |
| casc_stb_i | input | 1 | Overflow/underflow strobe of another channel |
| cnt_en_o | output | 1 | One-cycle count-enable pulse |

## Verification
A wrong prescaler count or tap shows up as a pulse in the wrong phase. That becomes visible within one period of the selected divider, at most 64 cycles for the taps exercised. A stale or wrongly cleared history register gives an extra or missing pulse in the very cycle of a source change or two cycles after a pin edge. A decode fault gives pulses on a source that should be silent, or the wrong pin or cascade routing. Either is visible as soon as that source toggles.

// File: rtl/tcs_pkg.sv
package tcs_pkg;

  typedef enum logic [2:0] {
    SRC_NONE,
    SRC_SYS,
    SRC_TAP,
    SRC_PIN,
    SRC_CASC
  } src_kind_e;

  // edge mode: 00 rising, 01 falling, 1x both
  function automatic logic edge_hit(input logic [1:0] mode, input logic cur, input logic prv);
    logic hit;
    case (mode)
      2'b00:   hit = cur & ~prv;
      2'b01:   hit = ~cur & prv;
      default: hit = cur ^ prv;
    endcase
    return hit;
  endfunction

  // divide by 4**log4: the most significant divided bit of the prescaler
  function automatic int unsigned tap_bit(input int unsigned log4);
    return 2 * log4 - 1;
  endfunction

endpackage

// File: rtl/tcs_prescaler.sv
module tcs_prescaler #(
  parameter int unsigned PRE_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PRE_W-1:0] cnt_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_o + 1'b1;
  end

endmodule

// File: rtl/tcs_pin_sync.sv
module tcs_pin_sync #(
  parameter int unsigned N_PINS = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_PINS-1:0] pins_i,
  output logic [N_PINS-1:0] lvl_o
);

  for (genvar g = 0; g < N_PINS; g++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], pins_i[g]};
    end
    assign lvl_o[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/tcs_src_decode.sv
module tcs_src_decode
  import tcs_pkg::*;
#(
  parameter bit          DIV256_EN  = 1'b0,
  parameter bit          DIV1024_EN = 1'b0,
  parameter bit          CASCADE_EN = 1'b0,
  parameter bit          EXT_CD_EN  = 1'b1,
  parameter int unsigned TAP_W      = 4
) (
  input  logic [2:0]       sel_i,
  output src_kind_e        kind_o,
  output logic [TAP_W-1:0] tap_o,
  output logic [1:0]       pin_o
);

  always_comb begin
    kind_o = SRC_NONE;
    tap_o  = '0;
    pin_o  = 2'd0;
    case (sel_i)
      3'b000: kind_o = SRC_SYS;
      3'b001, 3'b010, 3'b011: begin
        kind_o = SRC_TAP;
        tap_o  = TAP_W'(tap_bit(int'(sel_i)));
      end
      3'b100, 3'b101: begin
        kind_o = SRC_PIN;
        pin_o  = sel_i[1:0];
      end
      3'b110: begin
        if (EXT_CD_EN) begin
          kind_o = SRC_PIN;
          pin_o  = 2'd2;
        end else if (DIV256_EN) begin
          kind_o = SRC_TAP;
          tap_o  = TAP_W'(tap_bit(4));
        end
      end
      default: begin
        if (EXT_CD_EN) begin
          kind_o = SRC_PIN;
          pin_o  = 2'd3;
        end else if (CASCADE_EN) begin
          kind_o = SRC_CASC;
        end else if (DIV1024_EN) begin
          kind_o = SRC_TAP;
          tap_o  = TAP_W'(tap_bit(5));
        end
      end
    endcase
  end

endmodule

// File: rtl/tmr_cnt_en_sel.sv
module tmr_cnt_en_sel
  import tcs_pkg::*;
#(
  parameter bit          DIV256_EN  = 1'b0,
  parameter bit          DIV1024_EN = 1'b0,
  parameter bit          CASCADE_EN = 1'b0,
  parameter bit          EXT_CD_EN  = 1'b1,
  parameter int unsigned PRE_W      = 10,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] src_sel_i,
  input  logic [1:0] edge_sel_i,
  input  logic [3:0] ext_clk_i,
  input  logic       casc_stb_i,
  output logic       cnt_en_o
);

  localparam int unsigned N_PINS = 4;
  localparam int unsigned TAP_W  = $clog2(PRE_W);

  logic [PRE_W-1:0]  pre_cnt;
  logic [N_PINS-1:0] pin_lvl;
  src_kind_e         src_kind;
  logic [TAP_W-1:0]  tap_idx;
  logic [1:0]        pin_idx;

  // named internal events, visible to the checker
  logic       sel_lvl;    // level of the currently selected source
  logic       lvl_q;      // history: that level one cycle ago
  logic [2:0] sel_q;      // source code one cycle ago
  logic       hist_vld;   // history usable (low right after reset)
  logic       src_chg;    // source code differs from last cycle
  logic       raw_hit;    // edge found before gating

  tcs_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cnt_o  (pre_cnt)
  );

  tcs_pin_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pins_i (ext_clk_i),
    .lvl_o  (pin_lvl)
  );

  tcs_src_decode #(
    .DIV256_EN  (DIV256_EN),
    .DIV1024_EN (DIV1024_EN),
    .CASCADE_EN (CASCADE_EN),
    .EXT_CD_EN  (EXT_CD_EN),
    .TAP_W      (TAP_W)
  ) u_dec (
    .sel_i  (src_sel_i),
    .kind_o (src_kind),
    .tap_o  (tap_idx),
    .pin_o  (pin_idx)
  );

  always_comb begin
    case (src_kind)
      SRC_TAP: sel_lvl = pre_cnt[tap_idx];
      SRC_PIN: sel_lvl = pin_lvl[pin_idx];
      default: sel_lvl = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= 3'b000;
      lvl_q    <= 1'b0;
      hist_vld <= 1'b0;
    end else begin
      sel_q    <= src_sel_i;
      lvl_q    <= sel_lvl;
      hist_vld <= 1'b1;
    end
  end

  assign src_chg = (src_sel_i != sel_q);

  // undivided clock and cascade ignore the edge field (rising behaviour)
  always_comb begin
    case (src_kind)
      SRC_SYS:          raw_hit = 1'b1;
      SRC_CASC:         raw_hit = casc_stb_i;
      SRC_TAP, SRC_PIN: raw_hit = edge_hit(edge_sel_i, sel_lvl, lvl_q);
      default:          raw_hit = 1'b0;
    endcase
  end

  assign cnt_en_o = hist_vld & ~src_chg & raw_hit;

endmodule

// File: rtl/tmr_cnt_en_sel_chk.sv
module tmr_cnt_en_sel_chk
  import tcs_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] src_sel_i,
  input logic       casc_stb_i,
  input logic       cnt_en_o,
  input src_kind_e  src_kind,
  input logic       hist_vld
);

  // R1
  always_comb begin
    if (!rst_ni) rst_quiet_chk: assert (!cnt_en_o);
  end

  // R2
  sys_every_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i == 3'b000 && $past(src_sel_i) == 3'b000 && hist_vld) |-> cnt_en_o);

  // R3
  tap_single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_kind == SRC_TAP && $stable(src_sel_i) && cnt_en_o) |=> !cnt_en_o);

  // R7
  sel_change_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_sel_i != $past(src_sel_i)) |-> !cnt_en_o);

  // R9
  casc_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_kind == SRC_CASC && hist_vld && $stable(src_sel_i)) |-> (cnt_en_o == casc_stb_i));

  // R10
  no_source_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_kind == SRC_NONE) |-> !cnt_en_o);

endmodule

bind tmr_cnt_en_sel tmr_cnt_en_sel_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .src_sel_i  (src_sel_i),
  .casc_stb_i (casc_stb_i),
  .cnt_en_o   (cnt_en_o),
  .src_kind   (src_kind),
  .hist_vld   (hist_vld)
);

// File: tb/tmr_cnt_en_sel_tb_top.sv
module tmr_cnt_en_sel_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] sel = 3'b000;
  logic [1:0] edg = 2'b00;
  logic [3:0] pins = 4'b0000;
  logic       casc = 1'b0;
  logic       out_a;
  logic [2:0] sel_b = 3'b110;
  logic [1:0] edg_b = 2'b00;
  logic       out_b;

  int n_chk = 0;
  int n_err = 0;
  logic [9:0] m_cnt;

  always #4 clk = ~clk;

  // default channel: pins C and D present
  tmr_cnt_en_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel), .edge_sel_i(edg),
    .ext_clk_i(pins), .casc_stb_i(casc), .cnt_en_o(out_a)
  );

  // channel without pins C/D and /256, with cascade: 110 = none, 111 = cascade
  tmr_cnt_en_sel #(.EXT_CD_EN(1'b0), .DIV256_EN(1'b0), .CASCADE_EN(1'b1)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .src_sel_i(sel_b), .edge_sel_i(edg_b),
    .ext_clk_i(pins), .casc_stb_i(casc), .cnt_en_o(out_b)
  );

  // reference prescaler count
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_cnt <= '0;
    else        m_cnt <= m_cnt + 10'd1;
  end

  // {sel[2:0], edge[1:0], cycles[7:0]}
  localparam logic [12:0] VEC [9] = '{
    {3'b000, 2'b00, 8'd8},
    {3'b000, 2'b01, 8'd8},
    {3'b001, 2'b00, 8'd16},
    {3'b001, 2'b01, 8'd16},
    {3'b001, 2'b10, 8'd16},
    {3'b010, 2'b00, 8'd40},
    {3'b010, 2'b11, 8'd40},
    {3'b011, 2'b01, 8'd140},
    {3'b011, 2'b10, 8'd140}
  };

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %0b expected %0b at t=%0t", req, got, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  function automatic logic tap_exp(input logic [2:0] code, input logic [1:0] e, input logic [9:0] m);
    int n;
    logic cur;
    logic prv;
    logic [9:0] pm;
    n   = 1 << (2 * code);
    pm  = m - 10'd1;
    cur = (int'(m) % n) >= n / 2;
    prv = (int'(pm) % n) >= n / 2;
    if (e == 2'b00) return cur && !prv;
    if (e == 2'b01) return !cur && prv;
    return cur != prv;
  endfunction

  // drive a pin change on an already selected pin; expect pulse two edges later
  task automatic pin_case(input int idx, input logic [1:0] e, input logic lvl, input logic exp, input string req);
    tick(); sel = 3'(4 + idx); edg = e;
    #1;
    repeat (4) tick();
    pins[idx] = lvl;
    #1;
    tick(); #1; chk(out_a, 1'b0, req);
    tick(); #1; chk(out_a, exp, req);
    tick(); #1; chk(out_a, 1'b0, req);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [2:0] last_sel;
    // R1: quiet in reset and in the first cycle after release
    repeat (3) tick();
    #1; chk(out_a, 1'b0, "R1");
    tick(); rst_n = 1'b1;
    #1; chk(out_a, 1'b0, "R1");
    tick(); #1; chk(out_a, 1'b1, "R2");
    repeat (3) tick();

    // table walk: R2 (code 000), R3 (edge 00), R4 (edge 01), R5 (edge 1x)
    last_sel = 3'b000;
    foreach (VEC[v]) begin
      logic [2:0] vs;
      logic [1:0] ve;
      string req;
      vs = VEC[v][12:10];
      ve = VEC[v][9:8];
      req = (vs == 3'b000) ? "R2" : (ve == 2'b00) ? "R3" : (ve == 2'b01) ? "R4" : "R5";
      for (int c = 0; c < int'(VEC[v][7:0]); c++) begin
        logic exp;
        tick();
        if (c == 0) begin sel = vs; edg = ve; end
        #1;
        if (c == 0 && vs != last_sel) exp = 1'b0;
        else if (vs == 3'b000)        exp = 1'b1;
        else                          exp = tap_exp(vs, ve, m_cnt);
        chk(out_a, exp, (c == 0 && vs != last_sel) ? "R7" : req);
      end
      last_sel = vs;
    end

    // R7: leaving the undivided clock gives a quiet change cycle
    tick(); sel = 3'b000; #1;
    tick(); #1; chk(out_a, 1'b1, "R2");
    tick(); sel = 3'b001; #1; chk(out_a, 1'b0, "R7");

    // R6: external pins, each edge mode
    pin_case(0, 2'b00, 1'b1, 1'b1, "R6 pinA rise/rise");
    pin_case(0, 2'b00, 1'b0, 1'b0, "R6 pinA fall/rise");
    pin_case(1, 2'b01, 1'b1, 1'b0, "R6 pinB rise/fall");
    pin_case(1, 2'b01, 1'b0, 1'b1, "R6 pinB fall/fall");
    pin_case(2, 2'b10, 1'b1, 1'b1, "R6 pinC rise/both");
    pin_case(2, 2'b11, 1'b0, 1'b1, "R6 pinC fall/both");
    pin_case(3, 2'b11, 1'b1, 1'b1, "R6 pinD rise/both");

    // R7: switch from low pin A to already-high pin C: no false pulse
    tick(); sel = 3'b100; edg = 2'b00; #1;
    tick(); pins[2] = 1'b1; #1;
    repeat (4) begin tick(); #1; chk(out_a, 1'b0, "R7 pinA quiet"); end
    tick(); sel = 3'b110; #1; chk(out_a, 1'b0, "R7 change cycle");
    repeat (3) begin tick(); #1; chk(out_a, 1'b0, "R7 after change"); end

    // R10 / R8: code 110 is empty on the second channel
    for (int c = 0; c < 20; c++) begin
      tick(); pins[2] = c[1]; casc = c[0]; #1;
      chk(out_b, 1'b0, "R10");
    end
    casc = 1'b0;

    // R9 / R8: code 111 is the cascade strobe on the second channel; edge ignored
    tick(); sel_b = 3'b111; edg_b = 2'b01; #1;
    tick(); #1; tick(); #1;
    for (int c = 0; c < 8; c++) begin
      logic s;
      s = (c % 3) != 1;
      tick(); casc = s; #1;
      chk(out_b, s, "R9 R8 cascade");
    end
    tick(); casc = 1'b0; #1; chk(out_b, 1'b0, "R9");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule